// File: doc/BRIEF.md
# Serial Receive Byte Assembler with Destination Filter

This block sits between a clock-recovery stage and a receive FIFO in a network controller. It takes a recovered serial bit stream and its clock. It counts bits only while carrier sense is high. In that window it looks for the delimiter that ends the preamble. From the delimiter onward it packs the following bits into bytes, least significant bit first, and presents each finished byte to the FIFO write port. It also keeps a running count of the bytes received in the current frame.

While the first six bytes stream in, the block decides whether the frame is meant for this station. A frame whose first bit on the wire is 0 is unicast. It passes only if all six bytes equal the programmed station address. A frame whose first bit is 1 is multicast. It passes only if a hash of its destination picks a set bit in a 64-bit filter. A frame that fails the test is reported to the protocol controller, and the FIFO is told to discard what it already holds. When the FIFO reports full, the block drops the byte and raises a sticky overflow flag.

Top module: `rx_deser_filter`

## Requirements
- R1: While `rstN` is low, every output is 0.
- R2: A bit is taken on a rising clock edge only when `carrierSense` is high at that edge. When `carrierSense` is low at an edge, the block discards any partial byte and clears its delimiter history. It then returns to hunting, so the next frame needs a full new delimiter.
- R3: The delimiter is four consecutive sampled bits 1, 0, 1, 1 in arrival order. The bit sampled on the following edge is bit 0 of the first byte.
- R4: Each byte is packed with the first-arriving bit as bit 0. `pushValid` is high for exactly one cycle, starting one cycle after the edge that samples the byte's eighth bit, and `pushData` then holds the byte.
- R5: `rxByteCount` is cleared one cycle after the delimiter's last bit is sampled. It then rises by one, one cycle after each completed byte of the frame. This includes bytes that are rejected or dropped.
- R6: A unicast frame (bit 0 of byte 0 is 0) passes only if byte k equals `physAddr[8k+7:8k]` for k = 0 to 5. On a pass, `frameAccept` pulses for one cycle, one cycle after the 48th bit after the delimiter is sampled.
- R7: For a multicast frame (bit 0 of byte 0 is 1), the block runs a 32-bit CRC over the 48 destination bits in arrival order. The CRC register starts at all ones. For each bit, the feedback is register bit 31 XOR the data bit; the register shifts left by one and, when the feedback is 1, is XORed with 0x04C11DB7. The hash index is register bits 31..26, with bit 31 as the index MSB. The frame passes only if `hashFilter[index]` is 1.
- R8: A frame that fails R6 or R7 causes `frameReject` and `fifoFlush` to pulse together, one cycle after the 48th bit. The sixth byte of that frame and every later byte are not pushed.
- R9: If `carrierSense` is low at an edge before the pass/fail decision has been made, `frameReject` and `fifoFlush` pulse one cycle later.
- R10: A byte that would be pushed while `fifoFull` is high at the edge that completes it is not pushed. In that case `overflow` goes high one cycle later and stays high until one cycle after the next delimiter completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered receive clock |
| rstN | input | 1 | Asynchronous reset, active low |
| carrierSense | input | 1 | High while a carrier is present; enables bit sampling |
| rxData | input | 1 | Recovered serial data bit |
| physAddr | input | 48 | Station address, byte k at bits 8k+7..8k |
| hashFilter | input | 64 | Multicast filter bits, indexed by the hash |
| fifoFull | input | 1 | Receive FIFO cannot take a byte this cycle |
| pushValid | output | 1 | Write strobe for the receive FIFO |
| pushData | output | 8 | Byte written when pushValid is high |
| fifoFlush | output | 1 | One-cycle request to empty the receive FIFO |
| overflow | output | 1 | Sticky flag: a byte was dropped on a full FIFO this frame |
| frameAccept | output | 1 | One-cycle pulse: destination passed the filter |
| frameReject | output | 1 | One-cycle pulse: destination failed, or carrier lost before the decision |
| rxByteCount | output | 11 | Bytes received since the last delimiter |

## Verification
Every output is registered, so each result is due one cycle after the edge that samples its deciding input. A byte and its count step follow the edge that takes the eighth bit. The verdict and flush follow the edge that takes bit 48, or the edge that first sees carrier low. Overflow follows the edge of the dropped byte, and its clearing follows the delimiter's last bit. The bench model advances on the same rising edge that the design samples on and holds the expected values for the cycle that follows. The bench then compares every output at the falling edge in between, so each check lands exactly in the cycle where the result is due.

// File: rtl/rx_deser_pkg.sv
package rx_deser_pkg;

  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_ADDR,
    ST_PASS,
    ST_DROP
  } rxState_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic huntShift;
    logic startFrame;
    logic dataShift;
    logic pushByte;
  } dpStrobes_t;

  // one serial step of the hash CRC
  function automatic logic [31:0] crcBit(input logic [31:0] crcIn, input logic bitIn);
    logic fb;
    fb = crcIn[31] ^ bitIn;
    return {crcIn[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
  endfunction

endpackage

// File: rtl/rx_deser_dp.sv
module rx_deser_dp
  import rx_deser_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 64,
  parameter int CNT_W      = 11
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    carrierSense,
  input  logic                    rxData,
  input  dpStrobes_t              strobes,
  input  logic [ADDR_BYTES*8-1:0] physAddr,
  input  logic [HASH_BITS-1:0]    hashFilter,
  output logic                    sfdHit,
  output logic                    byteDone,
  output logic                    addrLast,
  output logic                    isMcast,
  output logic                    unicastOk,
  output logic                    hashHit,
  output logic                    pushValid,
  output logic [7:0]              pushData,
  output logic [CNT_W-1:0]        byteCount
);

  localparam int IDX_W  = $clog2(ADDR_BYTES + 1);
  localparam int HASH_W = $clog2(HASH_BITS);

  logic [2:0]       hist;
  logic [6:0]       shReg;
  logic [2:0]       bitCnt;
  logic [IDX_W-1:0] addrIdx;
  logic             matchSoFar;
  logic             mcastReg;
  logic [31:0]      crcReg;
  logic [31:0]      crcNext;
  logic [7:0]       byteNow;
  logic [7:0]       expByte;
  logic             inAddr;
  logic             firstBit;
  logic [7:0]       addrByte [ADDR_BYTES];

  genvar g;
  generate
    for (g = 0; g < ADDR_BYTES; g++) begin : gAddrByte
      assign addrByte[g] = physAddr[g*8 +: 8];
    end
  endgenerate

  always_comb begin
    expByte = '0;
    for (int k = 0; k < ADDR_BYTES; k++) begin
      if (addrIdx == IDX_W'(k)) expByte = addrByte[k];
    end
  end

  assign byteNow   = {rxData, shReg};
  assign inAddr    = addrIdx < IDX_W'(ADDR_BYTES);
  assign firstBit  = (addrIdx == '0) && (bitCnt == 3'd0);
  assign crcNext   = crcBit(crcReg, rxData);
  assign sfdHit    = carrierSense && (hist == 3'b101) && rxData;
  assign byteDone  = strobes.dataShift && (bitCnt == 3'd7);
  assign addrLast  = byteDone && (addrIdx == IDX_W'(ADDR_BYTES - 1));
  assign isMcast   = mcastReg;
  assign unicastOk = matchSoFar && (byteNow == expByte);
  assign hashHit   = hashFilter[crcNext[31 -: HASH_W]];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist       <= '0;
      shReg      <= '0;
      bitCnt     <= '0;
      addrIdx    <= '0;
      matchSoFar <= 1'b0;
      mcastReg   <= 1'b0;
      crcReg     <= '1;
      byteCount  <= '0;
      pushValid  <= 1'b0;
      pushData   <= '0;
    end else begin
      pushValid <= strobes.pushByte;
      if (strobes.pushByte) pushData <= byteNow;

      if (!carrierSense || strobes.startFrame) hist <= '0;
      else if (strobes.huntShift)              hist <= {hist[1:0], rxData};

      if (strobes.startFrame) begin
        bitCnt     <= '0;
        addrIdx    <= '0;
        matchSoFar <= 1'b1;
        mcastReg   <= 1'b0;
        crcReg     <= '1;
        byteCount  <= '0;
      end else if (strobes.dataShift) begin
        shReg  <= byteNow[7:1];
        bitCnt <= bitCnt + 3'd1;
        if (firstBit) mcastReg <= rxData;
        if (inAddr)   crcReg   <= crcNext;
        if (byteDone) begin
          byteCount <= byteCount + 1'b1;
          if (inAddr) begin
            addrIdx    <= addrIdx + 1'b1;
            matchSoFar <= unicastOk;
          end
        end
      end
    end
  end

endmodule

// File: rtl/rx_deser_ctrl.sv
module rx_deser_ctrl
  import rx_deser_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       carrierSense,
  input  logic       fifoFull,
  input  logic       sfdHit,
  input  logic       byteDone,
  input  logic       addrLast,
  input  logic       isMcast,
  input  logic       unicastOk,
  input  logic       hashHit,
  output dpStrobes_t strobes,
  output logic       frameAccept,
  output logic       frameReject,
  output logic       fifoFlush,
  output logic       overflow
);

  rxState_e state, stateNext;
  logic inFrame, hunting, starting, verdictNow, passNow, wantPush, rejectNow;

  always_comb begin
    inFrame    = state != ST_HUNT;
    hunting    = carrierSense && !inFrame;
    starting   = hunting && sfdHit;
    verdictNow = (state == ST_ADDR) && addrLast;
    passNow    = isMcast ? hashHit : unicastOk;
    wantPush   = byteDone &&
                 ((state == ST_PASS) ||
                  ((state == ST_ADDR) && !(verdictNow && !passNow)));
    rejectNow  = (verdictNow && !passNow) || ((state == ST_ADDR) && !carrierSense);

    strobes.huntShift  = hunting;
    strobes.startFrame = starting;
    strobes.dataShift  = carrierSense && inFrame;
    strobes.pushByte   = wantPush && !fifoFull;

    stateNext = state;
    case (state)
      ST_HUNT: if (starting) stateNext = ST_ADDR;
      ST_ADDR: begin
        if (!carrierSense)   stateNext = ST_HUNT;
        else if (verdictNow) stateNext = passNow ? ST_PASS : ST_DROP;
      end
      default: if (!carrierSense) stateNext = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_HUNT;
      frameAccept <= 1'b0;
      frameReject <= 1'b0;
      fifoFlush   <= 1'b0;
      overflow    <= 1'b0;
    end else begin
      state       <= stateNext;
      frameAccept <= verdictNow && passNow;
      frameReject <= rejectNow;
      fifoFlush   <= rejectNow;
      if (starting)                  overflow <= 1'b0;
      else if (wantPush && fifoFull) overflow <= 1'b1;
    end
  end

endmodule

// File: rtl/rx_deser_filter.sv
module rx_deser_filter
  import rx_deser_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 64,
  parameter int CNT_W      = 11
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    carrierSense,
  input  logic                    rxData,
  input  logic [ADDR_BYTES*8-1:0] physAddr,
  input  logic [HASH_BITS-1:0]    hashFilter,
  input  logic                    fifoFull,
  output logic                    pushValid,
  output logic [7:0]              pushData,
  output logic                    fifoFlush,
  output logic                    overflow,
  output logic                    frameAccept,
  output logic                    frameReject,
  output logic [CNT_W-1:0]        rxByteCount
);

  dpStrobes_t strobes;
  logic sfdHit, byteDone, addrLast, isMcast, unicastOk, hashHit;

  rx_deser_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .carrierSense (carrierSense),
    .fifoFull     (fifoFull),
    .sfdHit       (sfdHit),
    .byteDone     (byteDone),
    .addrLast     (addrLast),
    .isMcast      (isMcast),
    .unicastOk    (unicastOk),
    .hashHit      (hashHit),
    .strobes      (strobes),
    .frameAccept  (frameAccept),
    .frameReject  (frameReject),
    .fifoFlush    (fifoFlush),
    .overflow     (overflow)
  );

  rx_deser_dp #(
    .ADDR_BYTES (ADDR_BYTES),
    .HASH_BITS  (HASH_BITS),
    .CNT_W      (CNT_W)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .carrierSense (carrierSense),
    .rxData       (rxData),
    .strobes      (strobes),
    .physAddr     (physAddr),
    .hashFilter   (hashFilter),
    .sfdHit       (sfdHit),
    .byteDone     (byteDone),
    .addrLast     (addrLast),
    .isMcast      (isMcast),
    .unicastOk    (unicastOk),
    .hashHit      (hashHit),
    .pushValid    (pushValid),
    .pushData     (pushData),
    .byteCount    (rxByteCount)
  );

endmodule

// File: rtl/rx_deser_filter_chk.sv
module rx_deser_filter_chk #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rstN,
  input logic             carrierSense,
  input logic             fifoFull,
  input logic             pushValid,
  input logic             frameAccept,
  input logic             frameReject,
  input logic [CNT_W-1:0] rxByteCount
);

  AST_PUSH_NEEDS_CARRIER: assert property (@(posedge clk) disable iff (!rstN)
    pushValid |-> $past(carrierSense)); // R2

  AST_PUSH_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    pushValid |=> !pushValid); // R4

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (rxByteCount != $past(rxByteCount)) |->
      ((rxByteCount == $past(rxByteCount) + 1'b1) || (rxByteCount == '0))); // R5

  AST_ACCEPT_NEEDS_CARRIER: assert property (@(posedge clk) disable iff (!rstN)
    frameAccept |-> $past(carrierSense)); // R6

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rstN)
    !(frameAccept && frameReject)); // R8

  AST_NO_PUSH_ON_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    frameReject |-> !pushValid); // R8

  AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    pushValid |-> !$past(fifoFull)); // R10

endmodule

bind rx_deser_filter rx_deser_filter_chk #(.CNT_W(CNT_W)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .carrierSense (carrierSense),
  .fifoFull     (fifoFull),
  .pushValid    (pushValid),
  .frameAccept  (frameAccept),
  .frameReject  (frameReject),
  .rxByteCount  (rxByteCount)
);

// File: tb/rx_deser_filter_test.sv
module rx_deser_filter_test;

  localparam int CNT_W = 11;

  logic clk = 1'b0, rstN = 1'b0, carrierSense = 1'b0, rxData = 1'b0, fifoFull = 1'b0;
  logic [47:0] physAddr   = 48'h5E_44_33_22_11_02;
  logic [63:0] hashFilter = '0;
  logic        pushValid, fifoFlush, overflow, frameAccept, frameReject;
  logic [7:0]  pushData;
  logic [CNT_W-1:0] rxByteCount;

  rx_deser_filter uut (
    .clk(clk), .rstN(rstN), .carrierSense(carrierSense), .rxData(rxData),
    .physAddr(physAddr), .hashFilter(hashFilter), .fifoFull(fifoFull),
    .pushValid(pushValid), .pushData(pushData), .fifoFlush(fifoFlush),
    .overflow(overflow), .frameAccept(frameAccept), .frameReject(frameReject),
    .rxByteCount(rxByteCount)
  );

  always #4 clk = ~clk;

  int vectors = 0, miscompares = 0, cyc = 0;
  bit checking = 0;
  int fullMode = 0; // 0 never, 1 random, 2 always

  // ---------------- behavioural reference ----------------
  bit mInFrame, mDecided, mPass, mWant;
  int mBits, mCnt;
  logic [7:0] mByte;
  logic [7:0] mAddr[$];
  bit mHunt[$];
  logic ePush, eAcc, eRej, eFl, eOvf;
  logic [7:0] eData;

  function automatic int hashIndex(input logic [47:0] dst);
    logic [31:0] c = '1;
    for (int n = 0; n < 48; n++) begin
      logic fb;
      fb = c[31] ^ dst[n];
      c = {c[30:0], 1'b0};
      if (fb) c = c ^ 32'h04C1_1DB7;
    end
    return int'(c[31:26]);
  endfunction

  function automatic bit verdict();
    logic [47:0] dst;
    for (int k = 0; k < 6; k++) dst[8*k +: 8] = mAddr[k];
    if (dst[0]) return hashFilter[hashIndex(dst)];   // R7
    return dst == physAddr;                          // R6
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mInFrame = 0; mDecided = 0; mPass = 0; mBits = 0; mCnt = 0;
      mHunt.delete(); mAddr.delete();
      ePush = 0; eAcc = 0; eRej = 0; eFl = 0; eOvf = 0; eData = '0;
    end else begin
      ePush = 0; eAcc = 0; eRej = 0; eFl = 0;
      if (!carrierSense) begin
        if (mInFrame && !mDecided) begin eRej = 1; eFl = 1; end  // R9
        mInFrame = 0;
        mHunt.delete();
      end else if (!mInFrame) begin
        mHunt.push_back(rxData);
        if (mHunt.size() > 4) void'(mHunt.pop_front());
        if (mHunt.size() == 4 && mHunt[0] && !mHunt[1] && mHunt[2] && mHunt[3]) begin
          mInFrame = 1; mDecided = 0; mPass = 0; mBits = 0; mCnt = 0; eOvf = 0;
          mAddr.delete(); mHunt.delete();
        end
      end else begin
        mByte[mBits] = rxData;
        mBits++;
        if (mBits == 8) begin
          mBits = 0;
          mCnt = (mCnt + 1) % (1 << CNT_W);
          if (!mDecided) begin
            mAddr.push_back(mByte);
            if (mAddr.size() == 6) begin
              mDecided = 1;
              mPass = verdict();
              mWant = mPass;
              if (mPass) eAcc = 1; else begin eRej = 1; eFl = 1; end
            end else mWant = 1;
          end else mWant = mPass;
          if (mWant) begin
            if (fifoFull) eOvf = 1;
            else begin ePush = 1; eData = mByte; end
          end
        end
      end
    end
  end

  // ---------------- comparison ----------------
  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      vectors++;
      cmp("R3 R4 pushValid", 32'(pushValid), 32'(ePush));
      if (ePush) cmp("R4 pushData", 32'(pushData), 32'(eData));
      cmp("R2 R5 rxByteCount", 32'(rxByteCount), 32'(mCnt));
      cmp("R6 R7 frameAccept", 32'(frameAccept), 32'(eAcc));
      cmp("R8 R9 frameReject", 32'(frameReject), 32'(eRej));
      cmp("R8 R9 fifoFlush", 32'(fifoFlush), 32'(eFl));
      cmp("R10 overflow", 32'(overflow), 32'(eOvf));
    end
  end

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      miscompares++;
      $display("FAIL watchdog: run hung at cycle %0d", cyc);
      finishRun();
    end
  end

  // ---------------- stimulus ----------------
  task automatic bitOut(input logic cs, input logic d);
    @(negedge clk);
    carrierSense = cs;
    rxData = d;
    fifoFull = (fullMode == 2) ? 1'b1 : (fullMode == 1) ? 1'($urandom_range(0, 1)) : 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) bitOut(1'b0, 1'($urandom_range(0, 1)));
  endtask

  // limit < 0 sends the whole frame, otherwise carrier drops after limit bits past the delimiter
  task automatic sendFrame(input logic [47:0] dst, input int nPay, input int limit);
    bit q[$];
    for (int n = 0; n < 48; n++) q.push_back(dst[n]);
    for (int b = 0; b < nPay; b++) begin
      logic [7:0] v;
      v = 8'($urandom);
      for (int i = 0; i < 8; i++) q.push_back(v[i]);
    end
    for (int i = 0; i < 3; i++) begin bitOut(1'b1, 1'b1); bitOut(1'b1, 1'b0); end
    bitOut(1'b1, 1'b1); bitOut(1'b1, 1'b1);   // R3 delimiter 1,0,1,1
    for (int n = 0; n < q.size(); n++) begin
      if (limit >= 0 && n >= limit) break;
      bitOut(1'b1, q[n]);
    end
    idle(4);
  endtask

  initial begin
    logic [47:0] mc;
    // R1: outputs during reset
    repeat (3) @(negedge clk);
    vectors++; cmp("R1 reset pushValid", 32'(pushValid), 0);
    vectors++; cmp("R1 reset accept/reject/flush", 32'({frameAccept, frameReject, fifoFlush}), 0);
    vectors++; cmp("R1 reset overflow", 32'(overflow), 0);
    vectors++; cmp("R1 reset rxByteCount", 32'(rxByteCount), 0);
    rstN = 1'b1;
    checking = 1;
    idle(5);

    sendFrame(physAddr, 10, -1);                     // R6 unicast match
    sendFrame(physAddr ^ (48'h1 << 47), 6, -1);      // R6 R8 mismatch in last byte
    sendFrame(physAddr ^ 48'h80, 6, -1);             // R6 R8 mismatch in first byte
    mc = 48'hAB_CD_EF_00_5E_01;
    hashFilter = 64'h1 << hashIndex(mc);
    sendFrame(mc, 8, -1);                            // R7 hash hit
    hashFilter = ~(64'h1 << hashIndex(mc));
    sendFrame(mc, 8, -1);                            // R7 R8 hash miss
    hashFilter = '1;
    sendFrame('1, 5, -1);                            // R7 broadcast
    fullMode = 1; sendFrame(physAddr, 20, -1);       // R10 random full
    fullMode = 2; sendFrame(physAddr, 4, -1);        // R10 full throughout
    fullMode = 0; sendFrame(physAddr, 3, -1);        // R10 overflow cleared by new delimiter
    sendFrame(physAddr, 10, 20);                     // R9 carrier lost in address
    sendFrame(physAddr, 10, 48 + 24 + 5);            // R2 carrier lost mid-byte
    // R2 R3: carrier lost mid-preamble, then bits that never form the delimiter
    bitOut(1'b1, 1'b1); bitOut(1'b1, 1'b0); bitOut(1'b1, 1'b1);
    bitOut(1'b0, 1'b1);
    bitOut(1'b1, 1'b1); bitOut(1'b1, 1'b1); bitOut(1'b1, 1'b0); bitOut(1'b1, 1'b0);
    idle(3);
    sendFrame(physAddr, 2, -1);

    for (int f = 0; f < 60; f++) begin
      logic [47:0] dst;
      dst = ($urandom_range(0, 1) == 1) ? physAddr : {$urandom, $urandom}[47:0];
      if ($urandom_range(0, 3) == 0) dst[0] = 1'b1;
      hashFilter = {$urandom, $urandom};
      fullMode = ($urandom_range(0, 3) == 0) ? 1 : 0;
      sendFrame(dst, $urandom_range(0, 24),
                ($urandom_range(0, 4) == 0) ? $urandom_range(0, 120) : -1);
    end
    fullMode = 0;
    idle(5);
    finishRun();
  end

endmodule